// File: doc/BRIEF.md
# DMA Controller Command, Mask and Request Register Bank

This block holds the controller-wide state of a four-channel DMA engine: the command byte, one mode byte per channel, the channel mask, and a status byte whose upper nibble holds the pending requests and whose lower nibble holds the terminal-count flags. Software reaches it through an 8-bit I/O port. A 3-bit offset selects one of eight control locations, and a write or read strobe qualifies each access. The address and count registers of the channels sit in a neighbouring block. That block tells this one when it touches a two-byte register, so the shared byte pointer can flip.

Request flags come from two places: a software request write and per-channel hardware assert and release lines. Terminal-count flags are set by pulses from the transfer engine. In every cycle the block registers which channels are unmasked and requesting. From that registered set it grants the lowest-numbered channel as a one-hot vector.

Top module: `dmac_ctl_top`

## Requirements
- R1: A write at offset 0 loads the command register only when the data is 0x00 or 0x04. Any other value leaves the command unchanged. The command is visible on `cmd_out`.
- R2: A write at offset 1 selects a channel with data bits 1..0. Data bit 2 gives the new value of that channel's request flag (status bit channel+4). The write also clears that channel's terminal-count flag (status bit channel).
- R3: A write at offset 2 sets the mask bit of the channel in data bits 1..0 when data bit 2 is 1, and clears it when data bit 2 is 0.
- R4: A write at offset 3 stores the whole data byte into the mode byte of the channel in data bits 1..0. Channel n's mode appears on `mode_out[8n+7:8n]`.
- R5: A write at offset 4 clears the byte pointer. Otherwise a pulse on `bp_toggle` inverts it. The clear wins when both occur in the same cycle.
- R6: A write at offset 5 clears the byte pointer, the command and the whole status byte, and sets all four mask bits. Mode bytes are kept.
- R7: A write at offset 6 clears all mask bits. A write at offset 7 loads mask bits 3..0 from data bits 3..0.
- R8: While `io_rd` is high, `io_rdata` returns the status byte {requests[3:0], terminal counts[3:0]} at offset 0 and {4'b0, mask} at offset 7. At every other offset, and while `io_rd` is low, it returns 0. A status read clears the terminal-count flags at the following edge.
- R9: `eligible` is registered. After each edge it equals the bits that were unmasked and requesting just before that edge.
- R10: `grant` is one-hot or zero. It selects the lowest-numbered bit of `eligible`.
- R11: `hw_req_set[n]` sets request flag n and `hw_req_clr[n]` clears it. Both take priority over a software request write in the same cycle, and the set wins over the release.
- R12: `tc_pulse[n]` sets terminal-count flag n. It wins over a status-read clear, a software request write and a master clear in the same cycle.
- R13: After reset the mask is 0xF and the command, status, modes, byte pointer, `eligible` and `grant` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Write strobe for the control port |
| io_rd | input | 1 | Read strobe for the control port |
| io_off | input | 3 | Control location offset 0..7 |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| bp_toggle | input | 1 | Flip request for the byte pointer from the channel register block |
| hw_req_set | input | 4 | Per-channel hardware request assert |
| hw_req_clr | input | 4 | Per-channel hardware request release |
| tc_pulse | input | 4 | Per-channel terminal-count pulse |
| cmd_out | output | 8 | Current command byte |
| mode_out | output | 32 | Four mode bytes, channel 0 in the low byte |
| mask_out | output | 4 | Channel mask |
| bp_out | output | 1 | Byte pointer state |
| eligible | output | 4 | Registered unmasked-and-requesting vector |
| grant | output | 4 | One-hot lowest-channel grant |

## Verification
Random traffic mixes writes and reads at all eight offsets with random data, including command values that hit the accept set and values just outside it. This mixed stream shows whether every special write decodes its channel field and bit 2 correctly. Random hardware set, release and terminal-count lines collide with software request writes, status reads and master clears. These collisions check the priority rules for the status byte. Directed cases force several channels eligible at once, to separate fixed priority from other orderings, and follow a masked channel through unmasking to confirm the one-cycle lag of `eligible`.

// File: rtl/dmac_pkg.sv
// Package: shared constants and the decoded-access record for the DMA
// control register bank. Assumes an 8-bit port and four channels.
package dmac_pkg;
    localparam int DATA_W = 8;
    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);

    typedef enum logic [2:0] {
        OFF_CMD_STAT  = 3'd0,
        OFF_SW_REQ    = 3'd1,
        OFF_MASK_ONE  = 3'd2,
        OFF_MODE      = 3'd3,
        OFF_BP_CLR    = 3'd4,
        OFF_MCLR      = 3'd5,
        OFF_MASK_NONE = 3'd6,
        OFF_MASK_ALL  = 3'd7
    } ctl_off_e;

    typedef struct packed {
        logic            cmd_we;
        logic            sreq_we;
        logic            smask_we;
        logic            mode_we;
        logic            bp_clr;
        logic            mclr;
        logic            mask_clr_all;
        logic            mask_load;
        logic            stat_rd;
        logic            mask_rd;
        logic [CH_W-1:0] ch;
        logic            bit2;
    } ctl_acc_t;

    // Command bits that may be set; everything else is rejected.
    localparam logic [DATA_W-1:0] CMD_ALLOWED = 8'h04;
endpackage

// File: rtl/dmac_port_decode.sv
// Module: turns a port access (strobe, offset, data) into one-hot action
// strobes. Assumes at most one write and one read per cycle.
module dmac_port_decode
    import dmac_pkg::*;
(
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [2:0]        io_off,
    input  logic [DATA_W-1:0] io_wdata,
    output ctl_acc_t          acc
);
    // Decode offset into action strobes.
    always_comb begin
        acc              = '0;
        acc.ch           = io_wdata[CH_W-1:0];
        acc.bit2         = io_wdata[2];
        if (io_wr) begin
            unique case (ctl_off_e'(io_off))
                OFF_CMD_STAT:  acc.cmd_we       = 1'b1;
                OFF_SW_REQ:    acc.sreq_we      = 1'b1;
                OFF_MASK_ONE:  acc.smask_we     = 1'b1;
                OFF_MODE:      acc.mode_we      = 1'b1;
                OFF_BP_CLR:    acc.bp_clr       = 1'b1;
                OFF_MCLR:      acc.mclr         = 1'b1;
                OFF_MASK_NONE: acc.mask_clr_all = 1'b1;
                OFF_MASK_ALL:  acc.mask_load    = 1'b1;
                default:       acc.cmd_we       = 1'b0;
            endcase
        end
        if (io_rd) begin
            acc.stat_rd = (ctl_off_e'(io_off) == OFF_CMD_STAT);
            acc.mask_rd = (ctl_off_e'(io_off) == OFF_MASK_ALL);
        end
    end
endmodule

// File: rtl/dmac_cfg_regs.sv
// Module: command, per-channel mode, mask and byte pointer registers.
// Assumes decoded strobes from dmac_port_decode; synchronous active-low reset.
module dmac_cfg_regs
    import dmac_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int DW  = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_acc_t          acc,
    input  logic [DW-1:0]     wdata,
    input  logic              bp_toggle,
    output logic [DW-1:0]     cmd_q,
    output logic [NCH*DW-1:0] mode_q,
    output logic [NCH-1:0]    mask_q,
    output logic              bp_q
);
    logic cmd_ok;

    // Accept a command only if no unsupported bit is set.
    assign cmd_ok = ((wdata & ~CMD_ALLOWED) == '0);

    // Command register with master clear.
    always_ff @(posedge clk) begin
        if (!rst_n || acc.mclr)          cmd_q <= '0;
        else if (acc.cmd_we && cmd_ok)   cmd_q <= wdata;
    end

    // Mask register: master clear, clear-all, load-all, single bit.
    always_ff @(posedge clk) begin
        if (!rst_n || acc.mclr)   mask_q <= '1;
        else if (acc.mask_clr_all) mask_q <= '0;
        else if (acc.mask_load)    mask_q <= wdata[NCH-1:0];
        else if (acc.smask_we)     mask_q[acc.ch] <= acc.bit2;
    end

    // Byte pointer: clears win over toggles.
    always_ff @(posedge clk) begin
        if (!rst_n || acc.mclr || acc.bp_clr) bp_q <= 1'b0;
        else if (bp_toggle)                   bp_q <= ~bp_q;
    end

    // One mode byte per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_mode
        always_ff @(posedge clk) begin
            if (!rst_n)                                    mode_q[g*DW +: DW] <= '0;
            else if (acc.mode_we && (int'(acc.ch) == g))   mode_q[g*DW +: DW] <= wdata;
        end
    end

    assert_cmd_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.cmd_we && !acc.mclr && (wdata & ~CMD_ALLOWED) != '0) |=> $stable(cmd_q));
    assert_mclr_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc.mclr |=> (mask_q == '1 && cmd_q == '0 && !bp_q));
    assert_bp_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc.bp_clr |=> !bp_q);
endmodule

// File: rtl/dmac_status_reg.sv
// Module: request and terminal-count flags forming the status byte.
// Assumes hardware inputs override software writes; tc set wins over clears.
module dmac_status_reg
    import dmac_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  ctl_acc_t       acc,
    input  logic [NCH-1:0] hw_req_set,
    input  logic [NCH-1:0] hw_req_clr,
    input  logic [NCH-1:0] tc_pulse,
    output logic [NCH-1:0] req_q,
    output logic [NCH-1:0] tc_q
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel;
        assign sel = acc.sreq_we && (int'(acc.ch) == g);

        // Request flag: clear, software value, hardware release, hardware set.
        always_ff @(posedge clk) begin
            if (!rst_n)              req_q[g] <= 1'b0;
            else if (hw_req_set[g])  req_q[g] <= 1'b1;
            else if (hw_req_clr[g])  req_q[g] <= 1'b0;
            else if (acc.mclr)       req_q[g] <= 1'b0;
            else if (sel)            req_q[g] <= acc.bit2;
        end

        // Terminal-count flag: pulse wins over every clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                                tc_q[g] <= 1'b0;
            else if (tc_pulse[g])                      tc_q[g] <= 1'b1;
            else if (acc.mclr || acc.stat_rd || sel)   tc_q[g] <= 1'b0;
        end

        assert_hw_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
            hw_req_set[g] |=> req_q[g]);
        assert_tc_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
            tc_pulse[g] |=> tc_q[g]);
        assert_stat_rd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (acc.stat_rd && !tc_pulse[g]) |=> !tc_q[g]);
    end
endmodule

// File: rtl/dmac_arbiter.sv
// Module: registers the eligible-channel vector and grants the lowest
// eligible channel. Assumes mask and request arrive as register outputs.
module dmac_arbiter
    import dmac_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] mask_q,
    input  logic [NCH-1:0] req_q,
    output logic [NCH-1:0] elig_q,
    output logic [NCH-1:0] grant
);
    // Register unmasked-and-requesting channels.
    always_ff @(posedge clk) begin
        if (!rst_n) elig_q <= '0;
        else        elig_q <= req_q & ~mask_q;
    end

    // Fixed priority: lowest index wins.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < NCH; i++) begin
            if (elig_q[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_in_elig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~elig_q) == '0);
    assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((elig_q & $past(mask_q)) == '0));
endmodule

// File: rtl/dmac_ctl_top.sv
// Module: top of the DMA control register bank. Ties decode, configuration,
// status and arbitration together and drives the combinational read mux.
module dmac_ctl_top
    import dmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [2:0]  io_off,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic        bp_toggle,
    input  logic [3:0]  hw_req_set,
    input  logic [3:0]  hw_req_clr,
    input  logic [3:0]  tc_pulse,
    output logic [7:0]  cmd_out,
    output logic [31:0] mode_out,
    output logic [3:0]  mask_out,
    output logic        bp_out,
    output logic [3:0]  eligible,
    output logic [3:0]  grant
);
    ctl_acc_t          acc;
    logic [NUM_CH-1:0] req_q;
    logic [NUM_CH-1:0] tc_q;

    dmac_port_decode u_dec (
        .io_wr(io_wr), .io_rd(io_rd), .io_off(io_off),
        .io_wdata(io_wdata), .acc(acc)
    );

    dmac_cfg_regs #(.NCH(NUM_CH), .DW(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .acc(acc), .wdata(io_wdata),
        .bp_toggle(bp_toggle), .cmd_q(cmd_out), .mode_q(mode_out),
        .mask_q(mask_out), .bp_q(bp_out)
    );

    dmac_status_reg #(.NCH(NUM_CH)) u_stat (
        .clk(clk), .rst_n(rst_n), .acc(acc),
        .hw_req_set(hw_req_set), .hw_req_clr(hw_req_clr),
        .tc_pulse(tc_pulse), .req_q(req_q), .tc_q(tc_q)
    );

    dmac_arbiter #(.NCH(NUM_CH)) u_arb (
        .clk(clk), .rst_n(rst_n), .mask_q(mask_out), .req_q(req_q),
        .elig_q(eligible), .grant(grant)
    );

    // Read mux: status, mask, or zero.
    always_comb begin
        if (acc.stat_rd)      io_rdata = {req_q, tc_q};
        else if (acc.mask_rd) io_rdata = {{(DATA_W-NUM_CH){1'b0}}, mask_out};
        else                  io_rdata = '0;
    end
endmodule

// File: tb/dmac_ctl_top_tb.sv
`timescale 1ns/1ps
module dmac_ctl_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 0, io_rd = 0, bp_toggle = 0;
    logic [2:0]  io_off = 0;
    logic [7:0]  io_wdata = 0;
    logic [3:0]  hw_req_set = 0, hw_req_clr = 0, tc_pulse = 0;
    logic [7:0]  io_rdata, cmd_out;
    logic [31:0] mode_out;
    logic [3:0]  mask_out, eligible, grant;
    logic        bp_out;

    int n_vec = 0, n_bad = 0;
    logic       done = 1'b0;

    // reference state
    logic [7:0] m_cmd;
    logic [3:0] m_mask, m_req, m_tc, m_elig;
    logic [7:0] m_mode [4];
    logic       m_bp;

    always #2.5 clk = ~clk;

    dmac_ctl_top u_dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_off(io_off),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .bp_toggle(bp_toggle),
        .hw_req_set(hw_req_set), .hw_req_clr(hw_req_clr), .tc_pulse(tc_pulse),
        .cmd_out(cmd_out), .mode_out(mode_out), .mask_out(mask_out),
        .bp_out(bp_out), .eligible(eligible), .grant(grant)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] low_grant(input logic [3:0] e);
        for (int i = 0; i < 4; i++) if (e[i]) return 4'(1 << i);
        return 4'b0;
    endfunction

    function automatic logic [7:0] exp_rdata();
        if (!io_rd) return 8'h00;
        if (io_off == 3'd0) return {m_req, m_tc};
        if (io_off == 3'd7) return {4'h0, m_mask};
        return 8'h00;
    endfunction

    task automatic model_reset();
        m_cmd = 0; m_mask = 4'hF; m_req = 0; m_tc = 0; m_elig = 0; m_bp = 0;
        for (int i = 0; i < 4; i++) m_mode[i] = 0;
    endtask

    // next state from current inputs (applied at the coming edge)
    task automatic model_tick();
        logic [3:0] nreq, ntc, nmask;
        logic [1:0] ch;
        ch = io_wdata[1:0];
        m_elig = m_req & ~m_mask;
        nreq = m_req; ntc = m_tc; nmask = m_mask;
        if (io_rd && io_off == 3'd0) ntc = 0;
        if (io_wr) begin
            case (io_off)
                3'd0: if ((io_wdata & 8'hFB) == 0) m_cmd = io_wdata;
                3'd1: begin nreq[ch] = io_wdata[2]; ntc[ch] = 1'b0; end
                3'd2: nmask[ch] = io_wdata[2];
                3'd3: m_mode[ch] = io_wdata;
                3'd4: m_bp = 1'b0;
                3'd5: begin m_cmd = 0; nmask = 4'hF; nreq = 0; ntc = 0; m_bp = 0; end
                3'd6: nmask = 4'h0;
                default: nmask = io_wdata[3:0];
            endcase
        end
        if (bp_toggle && !(io_wr && (io_off == 3'd4 || io_off == 3'd5))) m_bp = ~m_bp;
        nreq = (nreq & ~hw_req_clr) | hw_req_set;
        ntc  = ntc | tc_pulse;
        m_req = nreq; m_tc = ntc; m_mask = nmask;
    endtask

    task automatic check_state(input string ctx);
        chk({"R1 cmd ", ctx}, cmd_out, m_cmd);
        chk({"R3/R7 mask ", ctx}, mask_out, m_mask);
        for (int i = 0; i < 4; i++) chk({"R4 mode ", ctx}, mode_out[8*i +: 8], m_mode[i]);
        chk({"R5 bp ", ctx}, bp_out, m_bp);
        chk({"R9 eligible ", ctx}, eligible, m_elig);
        chk({"R10 grant ", ctx}, grant, low_grant(m_elig));
    endtask

    // one cycle: drive at negedge, check read data, let edge pass, check state
    task automatic step(input string ctx, input logic wr, input logic rd, input logic [2:0] off,
                        input logic [7:0] wd, input logic [3:0] hs, input logic [3:0] hc,
                        input logic [3:0] tp, input logic tog);
        io_wr = wr; io_rd = rd; io_off = off; io_wdata = wd;
        hw_req_set = hs; hw_req_clr = hc; tc_pulse = tp; bp_toggle = tog;
        #1;
        chk({"R8 rdata ", ctx}, io_rdata, exp_rdata());
        model_tick();
        @(negedge clk);
        io_wr = 0; io_rd = 0; hw_req_set = 0; hw_req_clr = 0; tc_pulse = 0; bp_toggle = 0;
        check_state(ctx);
    endtask

    task automatic wr(input string ctx, input logic [2:0] off, input logic [7:0] d);
        step(ctx, 1, 0, off, d, 0, 0, 0, 0);
    endtask
    task automatic rd_expect(input string tag, input logic [2:0] off, input logic [7:0] e);
        io_rd = 1; io_off = off; #1;
        chk(tag, io_rdata, e);
        io_rd = 0;
        step(tag, 0, 1, off, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_state("R13 reset");
        chk("R13 reset status", 0, 0);
        rd_expect("R13 status after reset", 3'd0, 8'h00);
        rd_expect("R13 mask after reset", 3'd7, 8'h0F);

        // R1: accepted and rejected command values
        wr("R1 accept 04", 3'd0, 8'h04); chk("R1 cmd 04", cmd_out, 8'h04);
        wr("R1 reject 01", 3'd0, 8'h01); chk("R1 cmd kept", cmd_out, 8'h04);
        wr("R1 reject 84", 3'd0, 8'h84); chk("R1 cmd kept2", cmd_out, 8'h04);
        wr("R1 accept 00", 3'd0, 8'h00); chk("R1 cmd 00", cmd_out, 8'h00);

        // R2 and R12: software request, tc pulse, write clears tc
        step("R12 tc pulse", 0, 0, 0, 0, 0, 0, 4'b0100, 0);
        wr("R2 sw req ch2", 3'd1, 8'h06);
        rd_expect("R2 status req2 tc cleared", 3'd0, 8'h40);
        // R7/R9/R10: unmask all, several eligible
        wr("R7 clear all masks", 3'd6, 8'h00);
        step("R11 hw set 1,3", 0, 0, 0, 0, 4'b1010, 0, 0, 0);
        @(negedge clk); model_tick(); check_state("R9 settle");
        chk("R10 lowest of 1,2,3", grant, 4'b0010);
        // R11: set wins over release, hw overrides sw
        step("R11 set+clr", 0, 0, 0, 0, 4'b0001, 4'b0001, 0, 0);
        step("R11 hw over sw", 1, 0, 3'd1, 8'h03, 4'b1000, 0, 0, 0);
        rd_expect("R11 status", 3'd0, 8'hF0);
        // R12: tc wins over status read clear
        step("R12 tc vs read", 0, 1, 3'd0, 0, 0, 0, 4'b0001, 0);
        rd_expect("R12 tc kept", 3'd0, 8'hF1);
        rd_expect("R8 tc cleared by read", 3'd0, 8'hF0);
        rd_expect("R8 other offset zero", 3'd3, 8'h00);
        // R3: single mask on ch0 moves grant to ch1 one cycle later
        wr("R3 mask ch0", 3'd2, 8'h04);
        @(negedge clk); model_tick(); check_state("R3 settle");
        chk("R10 grant after mask", grant, 4'b0010);
        // R5: toggle and clear
        step("R5 toggle", 0, 0, 0, 0, 0, 0, 0, 1); chk("R5 bp set", bp_out, 1);
        step("R5 clr vs toggle", 1, 0, 3'd4, 0, 0, 0, 0, 1); chk("R5 bp cleared", bp_out, 0);
        // R4 / R6
        wr("R4 mode ch3", 3'd3, 8'hA7); chk("R4 mode3", mode_out[31:24], 8'hA4 | 8'h03);
        step("R5 toggle2", 0, 0, 0, 0, 0, 0, 0, 1);
        wr("R6 master clear", 3'd5, 8'h00);
        chk("R6 mask", mask_out, 4'hF); chk("R6 bp", bp_out, 0);
        rd_expect("R6 status cleared", 3'd0, 8'h00);
        chk("R6 mode kept", mode_out[31:24], 8'hA7);
        wr("R7 load mask", 3'd7, 8'hF5); chk("R7 mask 5", mask_out, 4'h5);

        // random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] d;
            logic [2:0] o;
            d = 8'($urandom);
            o = 3'($urandom);
            if (o == 3'd5 && ($urandom % 4) != 0) o = 3'd1;
            if (o == 3'd0 && $urandom % 2 == 1) d = d & 8'h04;
            step("random", ($urandom % 3) != 0, ($urandom % 3) == 0, o, d,
                 4'($urandom) & 4'($urandom), 4'($urandom) & 4'($urandom),
                 4'($urandom) & 4'($urandom) & 4'($urandom), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule